// File: doc/BRIEF.md
# Shared-Bus Arbiter with Phase-Aware Hold Rules

This block decides which of three masters drives one shared bus: a processor core, a DMA engine, and a descriptor-fed transfer engine. The transfer engine reads its control block from memory, moves data and writes the control block back. Ownership is re-evaluated only at bus-cycle boundaries. A boundary is the current owner's cycle-end strobe. At a boundary the arbiter first asks whether the owner must keep the bus. It answers from the phase and mode signals that the owner reports for the cycle that is ending. If the owner may let go, the bus goes to the highest-priority requester: transfer engine first, then DMA, then the processor. The processor also owns the bus when nobody requests.

The transfer engine keeps the bus throughout its control-block fetch, its first data move and its control-block write-back. It also keeps the bus for as long as it reports that more back-to-back transfers follow. The DMA engine always keeps the bus between the read half and the write half of a dual-address transfer. Inside a block or a burst it also keeps the bus, but only when the transfer engine is not requesting and the configuration bit `cfg_dma_nohold` is clear. In every other case the DMA engine gives the bus up at each boundary, and it may win the bus straight back through normal arbitration.

All pins are plain control signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure. Grants are registered and move one clock after the deciding boundary.

Top module: `bus_hold_arbiter`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `gnt_cpu`=1, `gnt_dma`=0, `gnt_dsc`=0 and `owner_id`=0.
- R2: Exactly one grant is high in every cycle. `owner_id` encodes it as 0=processor, 1=DMA, 2=transfer engine.
- R3: Grants and `owner_id` change only on the clock edge that samples the current owner's cycle-end strobe high. In any other cycle they hold their values, whatever the other inputs do.
- R4: At a boundary where the owner does not hold, the next owner is the transfer engine if `dsc_req`=1, otherwise the DMA engine if `dma_req`=1, otherwise the processor.
- R5: A transfer-engine boundary with `dsc_phase` equal to 1 (control-block fetch), 2 (first data move) or 3 (control-block write-back) keeps the transfer engine as owner.
- R6: A transfer-engine boundary with `dsc_phase`=0 keeps the transfer engine as owner when `dsc_run_more`=1. When `dsc_run_more`=0 it releases the bus to arbitration.
- R7: A DMA boundary with `dma_dual`=1 and `dma_rd_cyc`=1 keeps the DMA engine as owner, regardless of `dsc_req` and `cfg_dma_nohold`.
- R8: A DMA boundary with `dma_mode` equal to 1 (block) or 2 (burst) and `dma_unit_last`=0 keeps the DMA engine as owner only when `dsc_req`=0 and `cfg_dma_nohold`=0.
- R9: Every other DMA boundary releases the bus. This covers `dma_mode` 0 or 3, and `dma_unit_last`=1. The DMA engine wins the bus again at that same boundary if it is still the highest requester.
- R10: `cfg_dma_nohold` is sampled only at a DMA boundary. Setting it in the middle of a burst leaves the grant unchanged until the next DMA cycle end, which then releases the bus.
- R11: Cycle-end strobes from masters that do not currently own the bus have no effect on the grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dma_nohold | input | 1 | 1 = DMA block/burst hold-over disabled |
| cpu_cyc_end | input | 1 | Processor bus-cycle end strobe |
| dsc_req | input | 1 | Transfer-engine bus request |
| dsc_cyc_end | input | 1 | Transfer-engine bus-cycle end strobe |
| dsc_phase | input | 2 | Transfer-engine phase of the ending cycle: 0 data, 1 fetch, 2 first data, 3 write-back |
| dsc_run_more | input | 1 | More back-to-back transfers follow |
| dma_req | input | 1 | DMA activation request |
| dma_cyc_end | input | 1 | DMA bus-cycle end strobe |
| dma_mode | input | 2 | 0 single, 1 block, 2 burst, 3 treated as single |
| dma_dual | input | 1 | Dual-address transfer |
| dma_rd_cyc | input | 1 | Ending cycle is the read half of a dual-address pair |
| dma_unit_last | input | 1 | Ending cycle closes the current block or burst |
| gnt_cpu | output | 1 | Processor grant |
| gnt_dma | output | 1 | DMA grant |
| gnt_dsc | output | 1 | Transfer-engine grant |
| owner_id | output | 2 | Encoded current owner |

## Verification
One long ordered sequence of boundaries is driven, so that each step starts from the owner the previous step produced. Each hold rule is tried with its holding and its releasing input values side by side. For example, the DMA engine in burst mode is tried once with no competitor and once with `dsc_req` high, which separates the hold-over rule from plain priority. Further steps use strobes from non-owners, and a configuration change between boundaries, to tell a real boundary from a spurious one. The DMA release in single mode is paired with a continuing request, which separates "released and won back" from "never released". Directed cases then cover reset in the middle of a transfer and two masters requesting at once.

// File: rtl/bharb_pkg.sv
package bharb_pkg;
  localparam int NUM_MST = 3;
  localparam int OWN_W   = $clog2(NUM_MST);
  localparam int PH_W    = 2;
  localparam int MODE_W  = 2;

  typedef enum logic [OWN_W-1:0] {
    OWN_CPU = 2'd0,
    OWN_DMA = 2'd1,
    OWN_DSC = 2'd2
  } owner_t;

  typedef enum logic [PH_W-1:0] {
    PH_DATA  = 2'd0,
    PH_FETCH = 2'd1,
    PH_FIRST = 2'd2,
    PH_WBACK = 2'd3
  } dsc_phase_t;

  typedef enum logic [MODE_W-1:0] {
    MD_SINGLE = 2'd0,
    MD_BLOCK  = 2'd1,
    MD_BURST  = 2'd2,
    MD_RSVD   = 2'd3
  } dma_mode_t;
endpackage

// File: rtl/bharb_dsc_hold.sv
module bharb_dsc_hold
  import bharb_pkg::*;
(
  input  logic [PH_W-1:0] phase,
  input  logic            run_more,
  output logic            keep
);
  logic in_ctrl_phase;

  always_comb begin
    unique case (dsc_phase_t'(phase))
      PH_FETCH, PH_FIRST, PH_WBACK: in_ctrl_phase = 1'b1;
      default:                      in_ctrl_phase = 1'b0;
    endcase
    keep = in_ctrl_phase | run_more;
  end
endmodule

// File: rtl/bharb_dma_hold.sv
module bharb_dma_hold
  import bharb_pkg::*;
(
  input  logic              mode,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              dual,
  input  logic              rd_cyc,
  input  logic              unit_last,
  input  logic              higher_req,
  input  logic              nohold,
  output logic              keep
);
  logic pair_lock;
  logic grouped;
  logic soft_lock;

  always_comb begin
    pair_lock = dual & rd_cyc;
    unique case (dma_mode_t'(mode_sel))
      MD_BLOCK, MD_BURST: grouped = 1'b1;
      default:            grouped = 1'b0;
    endcase
    soft_lock = grouped & ~unit_last & ~higher_req & ~nohold;
    keep = mode & (pair_lock | soft_lock);
  end
endmodule

// File: rtl/bharb_prio_pick.sv
module bharb_prio_pick
  import bharb_pkg::*;
#(
  parameter int N = NUM_MST,
  parameter int W = OWN_W
) (
  input  logic [N-1:0] req,
  output logic [W-1:0] win
);
  always_comb begin
    win = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) win = W'(i);
    end
  end
endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter
  import bharb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_dma_nohold,
  input  logic       cpu_cyc_end,
  input  logic       dsc_req,
  input  logic       dsc_cyc_end,
  input  logic [1:0] dsc_phase,
  input  logic       dsc_run_more,
  input  logic       dma_req,
  input  logic       dma_cyc_end,
  input  logic [1:0] dma_mode,
  input  logic       dma_dual,
  input  logic       dma_rd_cyc,
  input  logic       dma_unit_last,
  output logic       gnt_cpu,
  output logic       gnt_dma,
  output logic       gnt_dsc,
  output logic [1:0] owner_id
);
  owner_t           own_q;
  owner_t           own_d;
  logic             bnd;
  logic             keep_dsc;
  logic             keep_dma;
  logic             keep_own;
  logic [OWN_W-1:0] pick;
  logic [NUM_MST-1:0] req_vec;

  // bit index equals owner code; higher index wins
  assign req_vec = {dsc_req, dma_req, 1'b1};

  bharb_prio_pick #(.N(NUM_MST), .W(OWN_W)) u_pick (
    .req (req_vec),
    .win (pick)
  );

  bharb_dsc_hold u_dsc_hold (
    .phase    (dsc_phase),
    .run_more (dsc_run_more),
    .keep     (keep_dsc)
  );

  bharb_dma_hold u_dma_hold (
    .mode       (own_q == OWN_DMA),
    .mode_sel   (dma_mode),
    .dual       (dma_dual),
    .rd_cyc     (dma_rd_cyc),
    .unit_last  (dma_unit_last),
    .higher_req (dsc_req),
    .nohold     (cfg_dma_nohold),
    .keep       (keep_dma)
  );

  always_comb begin
    unique case (own_q)
      OWN_DSC: begin bnd = dsc_cyc_end; keep_own = keep_dsc; end
      OWN_DMA: begin bnd = dma_cyc_end; keep_own = keep_dma; end
      default: begin bnd = cpu_cyc_end; keep_own = 1'b0;     end
    endcase
    own_d = own_q;
    if (bnd && !keep_own) own_d = owner_t'(pick);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) own_q <= OWN_CPU;
    else        own_q <= own_d;
  end

  assign gnt_cpu  = (own_q == OWN_CPU);
  assign gnt_dma  = (own_q == OWN_DMA);
  assign gnt_dsc  = (own_q == OWN_DSC);
  assign owner_id = own_q;

  assert_gnt_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({gnt_dsc, gnt_dma, gnt_cpu}) == 1);

  assert_no_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bnd |=> $stable(owner_id));

  assert_prio_dsc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bnd && !keep_own && dsc_req |=> gnt_dsc);

  assert_dsc_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_dsc && dsc_cyc_end && (dsc_phase != 2'd0) |=> gnt_dsc);

  assert_dsc_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_dsc && dsc_cyc_end && dsc_run_more |=> gnt_dsc);

  assert_dma_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_dma && dma_cyc_end && dma_dual && dma_rd_cyc |=> gnt_dma);

  assert_dma_group_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_dma && dma_cyc_end && (dma_mode == 2'd1 || dma_mode == 2'd2) &&
    !dma_unit_last && !dsc_req && !cfg_dma_nohold |=> gnt_dma);

  assert_nohold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_dma && dma_cyc_end && cfg_dma_nohold && !(dma_dual && dma_rd_cyc) &&
    !dma_req && !dsc_req |=> gnt_cpu);
endmodule

// File: tb/bus_hold_arbiter_tb_top.sv
module bus_hold_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 20;
  localparam int WDOG = 5000;

  // tag[19:16] cfg cpu_end dsc_req dsc_end dsc_ph[1:0] dsc_more
  // dma_req dma_end dma_mode[1:0] dma_dual dma_rd dma_last exp[1:0]
  localparam logic [19:0] VEC [NVEC] = '{
    20'b0011_0_0_0_0_00_0_1_0_10_0_0_0_00, // R3 no owner end
    20'b0100_0_1_0_0_00_0_1_0_10_0_0_0_01, // R4 cpu->dma
    20'b1000_0_0_0_0_00_0_1_1_10_0_0_0_01, // R8 burst hold
    20'b1000_0_0_1_0_00_0_1_1_10_0_0_0_10, // R8 dsc breaks burst
    20'b0101_0_0_1_1_01_0_1_0_00_0_0_0_10, // R5 fetch
    20'b0101_0_0_1_1_10_0_1_0_00_0_0_0_10, // R5 first data
    20'b0110_0_0_1_1_00_1_1_0_00_0_0_0_10, // R6 run more
    20'b0101_0_0_1_1_11_0_1_0_00_0_0_0_10, // R5 write-back
    20'b0110_0_0_0_1_00_0_1_1_00_0_0_0_01, // R6 release
    20'b1011_0_1_1_1_00_0_1_0_00_0_0_0_01, // R11 foreign strobes
    20'b0111_1_0_1_0_00_0_1_1_00_1_1_0_01, // R7 pair lock
    20'b1001_0_0_1_0_00_0_1_1_00_1_0_0_10, // R9 write half releases
    20'b0110_0_0_0_1_00_0_1_0_00_0_0_0_01, // R6 release to dma
    20'b1001_0_0_0_0_00_0_1_1_00_0_0_0_01, // R9 single re-win
    20'b1000_0_0_0_0_00_0_1_1_10_0_0_0_01, // R8 burst hold
    20'b0011_1_0_0_0_00_0_1_0_10_0_0_0_01, // R3 cfg set mid burst
    20'b1010_1_0_0_0_00_0_0_1_10_0_0_0_00, // R10 cfg at boundary
    20'b0100_0_1_0_0_00_0_0_0_00_0_0_0_00, // R4 default cpu
    20'b0100_0_1_0_0_00_0_1_0_01_0_0_0_01, // R4 cpu->dma block
    20'b1001_0_0_0_0_00_0_0_1_01_0_0_1_00  // R9 unit last
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_dma_nohold = 1'b0, cpu_cyc_end = 1'b0;
  logic dsc_req = 1'b0, dsc_cyc_end = 1'b0, dsc_run_more = 1'b0;
  logic [1:0] dsc_phase = 2'd0;
  logic dma_req = 1'b0, dma_cyc_end = 1'b0, dma_dual = 1'b0;
  logic dma_rd_cyc = 1'b0, dma_unit_last = 1'b0;
  logic [1:0] dma_mode = 2'd0;
  logic gnt_cpu, gnt_dma, gnt_dsc;
  logic [1:0] owner_id;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_hold_arbiter dut_i (
    .clk, .rst_n, .cfg_dma_nohold, .cpu_cyc_end,
    .dsc_req, .dsc_cyc_end, .dsc_phase, .dsc_run_more,
    .dma_req, .dma_cyc_end, .dma_mode, .dma_dual, .dma_rd_cyc, .dma_unit_last,
    .gnt_cpu, .gnt_dma, .gnt_dsc, .owner_id
  );

  task automatic check_owner(input string rq, input logic [1:0] exp);
    logic [4:0] act;
    logic [4:0] want;
    act  = {gnt_dsc, gnt_dma, gnt_cpu, owner_id};
    want = {exp == 2'd2, exp == 2'd1, exp == 2'd0, exp};
    n_chk++;
    if (act !== want) begin
      n_bad++;
      $display("FAIL %s: {dsc,dma,cpu,id} act=%b exp=%b", rq, act, want);
    end
  endtask

  task automatic apply(input logic [19:0] v);
    cfg_dma_nohold = v[15]; cpu_cyc_end = v[14];
    dsc_req = v[13]; dsc_cyc_end = v[12]; dsc_phase = v[11:10];
    dsc_run_more = v[9]; dma_req = v[8]; dma_cyc_end = v[7];
    dma_mode = v[6:5]; dma_dual = v[4]; dma_rd_cyc = v[3];
    dma_unit_last = v[2];
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: act=timeout exp=done");
    finish_run();
  end

  initial begin
    apply('0);
    dma_req = 1'b1; dsc_req = 1'b1; cpu_cyc_end = 1'b1;
    tick(); tick();
    check_owner("R1 in reset", 2'd0);
    apply('0);
    rst_n = 1'b1;
    #1;
    check_owner("R1 after reset", 2'd0);

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i]);
      tick();
      check_owner($sformatf("R%0d vec %0d", VEC[i][19:16], i), VEC[i][1:0]);
    end

    // R4 both request at a cpu boundary: transfer engine wins
    apply('0);
    cpu_cyc_end = 1'b1; dsc_req = 1'b1; dma_req = 1'b1;
    tick();
    check_owner("R4 dsc over dma", 2'd2);
    // R11 strobe held high from the old owner after handover: no effect
    apply('0);
    cpu_cyc_end = 1'b1; dma_cyc_end = 1'b1; dma_req = 1'b1;
    tick();
    check_owner("R11 cpu strobe ignored", 2'd2);
    // R1 reset in the middle of a transfer-engine run
    apply('0);
    dsc_req = 1'b1; dsc_run_more = 1'b1;
    rst_n = 1'b0;
    tick();
    check_owner("R1 mid-run reset", 2'd0);
    rst_n = 1'b1;
    // R8 block hold with dsc idle, then dsc request breaks it
    apply('0);
    cpu_cyc_end = 1'b1; dma_req = 1'b1;
    tick();
    apply('0);
    dma_req = 1'b1; dma_cyc_end = 1'b1; dma_mode = 2'd1;
    tick();
    check_owner("R8 block hold", 2'd1);
    dsc_req = 1'b1;
    tick();
    check_owner("R8 block yields to dsc", 2'd2);
    // R9 reserved mode behaves as single
    apply('0);
    dsc_cyc_end = 1'b1; dma_req = 1'b1;
    tick();
    apply('0);
    dma_cyc_end = 1'b1; dma_mode = 2'd3;
    tick();
    check_owner("R9 reserved mode releases", 2'd0);

    finish_run();
  end
endmodule